// File: doc/BRIEF.md
# DRAM Request Queue Scheduler

This block sits between a non-blocking cache and one DRAM channel on a split-transaction bus. It accepts line-sized read and write requests into a queue of parameterized depth. It then decides which queued request is sent to the channel next. Every read that reaches DRAM is split into two commands. The critical sub-burst carries the requested word and goes out first. The rest of the line follows later as the non-critical sub-burst. Writes wait in the queue while any read is pending. A read to a line that a queued write already holds is answered straight from that write and does not use the bus.

Commands are paced in bus cycles. Back-to-back commands need at least the address-phase length between them, and one extra turnaround cycle (0 or 1, by parameter) when the direction changes. Each bank is closed after every access. A bank therefore stays busy for the read latency or the write latency after each command it receives. Read completions leave with the request tag and a flag for the sub-burst kind, so the cache can retire misses out of order. A pulse with the tag marks the cycle in which write data may begin.

Top module: `dram_req_sched`

## Requirements
- R1: Out of reset, req_ready is high and cmd_valid, rd_done_valid, wr_start and fwd_valid are low.
- R2: Every read that is not coalesced produces exactly two commands with its tag and address. The first has cmd_crit=1 and the second has cmd_crit=0.
- R3: When the bus is free, the command chosen comes from the highest class with an entry whose bank is idle. The classes rank critical read sub-burst, then non-critical read sub-burst, then write. Within a class the oldest entry wins.
- R4: No write command is issued while any read entry, in either sub-burst state, is in the queue.
- R5: A read whose line address equals that of a queued write issues no command. The cycle after it is accepted, fwd_valid rises with its tag, and fwd_data carries the data of the youngest such write.
- R6: Two successive commands are at least T_ADDR (8) cycles apart. They are at least T_ADDR+TURN (9) cycles apart when one is a read and the other a write.
- R7: The bank of a request is the low log2(NBANKS) bits of its line address. A bank takes no command until T_RD (56) cycles after a read command to it, or T_WR (32) cycles after a write command, even when the next access is to the same line.
- R8: rd_done_valid pulses exactly T_RD cycles after each read command, with its tag and sub-burst flag. wr_start pulses exactly T_WR cycles after each write command, with its tag.
- R9: req_ready is low while DEPTH entries are queued. A request presented then is not taken and never yields a command or a response.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_tag | input | TAG_W | Request tag |
| req_wdata | input | DATA_W | Write data |
| cmd_valid | output | 1 | Command on the bus this cycle |
| cmd_write | output | 1 | Command is a write |
| cmd_crit | output | 1 | Read command is the critical sub-burst |
| cmd_addr | output | ADDR_W | Command line address |
| cmd_tag | output | TAG_W | Command tag |
| cmd_wdata | output | DATA_W | Write data of a write command |
| rd_done_valid | output | 1 | Read data starts for a sub-burst |
| rd_done_crit | output | 1 | Completing sub-burst is critical |
| rd_done_tag | output | TAG_W | Tag of the completing read |
| wr_start | output | 1 | Write data may start |
| wr_start_tag | output | TAG_W | Tag of that write |
| fwd_valid | output | 1 | Coalesced read answered from queue |
| fwd_tag | output | TAG_W | Tag of the coalesced read |
| fwd_data | output | DATA_W | Data taken from the queued write |

## Verification
The bench sets up a contention case that fixes exact command cycles. It checks the critical-before-non-critical-before-write order, the 8-cycle read spacing, the 56-cycle wait for a closed bank, and the 9-cycle gap when the direction turns. A scheduler that let writes pass pending reads, or forgot the turnaround, would shift those cycles. Two writes to one line followed by a read check that the read is forwarded from the younger write and never reaches the bus; stale or missing forwarding shows as wrong data or a stray command. Eight reads to one bank fill the queue, so backpressure and oldest-first ordering are checked together, and a request held while full must vanish without trace. Random traffic over a small line pool then checks spacing, bank hold and latency on every command.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

  typedef enum logic [1:0] {
    CLS_CRIT  = 2'd0,
    CLS_NCRIT = 2'd1,
    CLS_WRITE = 2'd2,
    CLS_NONE  = 2'd3
  } pick_cls_e;

  // Minimum distance between two command issues on the bus.
  function automatic int unsigned issue_gap(input int unsigned t_addr,
                                            input int unsigned turn,
                                            input logic dir_change);
    return t_addr + (dir_change ? turn : 0);
  endfunction

  // Counter load value that keeps a closed bank busy for its access time.
  function automatic int unsigned bank_hold(input int unsigned t_rd,
                                            input int unsigned t_wr,
                                            input logic is_wr);
    return (is_wr ? t_wr : t_rd) - 1;
  endfunction

endpackage

// File: rtl/dram_req_queue.sv
module dram_req_queue #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              push,
  input  logic                              push_wr,
  input  logic [ADDR_W-1:0]                 push_addr,
  input  logic [TAG_W-1:0]                  push_tag,
  input  logic [DATA_W-1:0]                 push_data,
  input  logic                              pop,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] pop_idx,
  input  logic                              mark,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] mark_idx,
  input  logic [ADDR_W-1:0]                 lk_addr,
  output logic                              lk_hit,
  output logic [DATA_W-1:0]                 lk_data,
  output logic [$clog2(DEPTH+1)-1:0]        cnt,
  output logic [DEPTH-1:0]                  live,
  output logic [DEPTH-1:0]                  q_wr,
  output logic [DEPTH-1:0]                  q_cdone,
  output logic [DEPTH-1:0][ADDR_W-1:0]      q_addr,
  output logic [DEPTH-1:0][TAG_W-1:0]       q_tag,
  output logic [DEPTH-1:0][DATA_W-1:0]      q_data
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             n_wr, n_cd;
  logic [DEPTH-1:0][ADDR_W-1:0] n_addr;
  logic [DEPTH-1:0][TAG_W-1:0]  n_tag;
  logic [DEPTH-1:0][DATA_W-1:0] n_data;
  logic [CNT_W-1:0]             n_cnt;

  // Entry 0 is always the oldest; removal shifts younger entries down.
  always_comb begin
    n_wr = q_wr; n_cd = q_cdone; n_addr = q_addr; n_tag = q_tag; n_data = q_data;
    n_cnt = cnt;
    if (mark) n_cd[mark_idx] = 1'b1;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx) begin
          n_wr[i]   = n_wr[i+1];
          n_cd[i]   = n_cd[i+1];
          n_addr[i] = n_addr[i+1];
          n_tag[i]  = n_tag[i+1];
          n_data[i] = n_data[i+1];
        end
      end
      n_cnt = n_cnt - 1'b1;
    end
    if (push) begin
      n_wr[n_cnt[IDX_W-1:0]]   = push_wr;
      n_cd[n_cnt[IDX_W-1:0]]   = 1'b0;
      n_addr[n_cnt[IDX_W-1:0]] = push_addr;
      n_tag[n_cnt[IDX_W-1:0]]  = push_tag;
      n_data[n_cnt[IDX_W-1:0]] = push_data;
      n_cnt = n_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      q_wr    <= '0;
      q_cdone <= '0;
      q_addr  <= '0;
      q_tag   <= '0;
      q_data  <= '0;
    end else begin
      cnt     <= n_cnt;
      q_wr    <= n_wr;
      q_cdone <= n_cd;
      q_addr  <= n_addr;
      q_tag   <= n_tag;
      q_data  <= n_data;
    end
  end

  // Live mask and youngest matching write (later index overrides).
  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      live[i] = (CNT_W'(i) < cnt);
      if (live[i] && q_wr[i] && (q_addr[i] == lk_addr)) begin
        lk_hit  = 1'b1;
        lk_data = q_data[i];
      end
    end
  end

  always_comb AST_CNT_BOUND: assert (cnt <= CNT_W'(DEPTH)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt < CNT_W'(DEPTH))); // R9

endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dram_sched_pkg::*;
#(
  parameter int NBANKS = 4,
  parameter int T_RD   = 56,
  parameter int T_WR   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue,
  input  logic [$clog2(NBANKS)-1:0]  issue_bank,
  input  logic                       issue_wr,
  output logic [NBANKS-1:0]          idle
);
  localparam int BANK_W   = $clog2(NBANKS);
  localparam int HOLD_MAX = (T_RD > T_WR) ? T_RD : T_WR;
  localparam int CW       = $clog2(HOLD_MAX + 1);

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [CW-1:0] busy_cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)
        busy_cnt <= '0;
      else if (issue && (issue_bank == BANK_W'(b)))
        busy_cnt <= CW'(bank_hold(T_RD, T_WR, issue_wr));
      else if (busy_cnt != '0)
        busy_cnt <= busy_cnt - 1'b1;
    end
    assign idle[b] = (busy_cnt == '0);
  end

  AST_BANK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> idle[issue_bank]); // R7

endmodule

// File: rtl/dram_issue_pick.sv
module dram_issue_pick
  import dram_sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANKS = 4
) (
  input  logic [DEPTH-1:0]                        live,
  input  logic [DEPTH-1:0]                        is_wr,
  input  logic [DEPTH-1:0]                        crit_done,
  input  logic [DEPTH-1:0][$clog2(NBANKS)-1:0]    ent_bank,
  input  logic [NBANKS-1:0]                       bank_idle,
  output logic                                    sel_valid,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0]  sel_idx,
  output pick_cls_e                               sel_cls,
  output logic                                    any_read
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] el_crit, el_nc, el_wr;

  function automatic logic [IDX_W-1:0] oldest(input logic [DEPTH-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  always_comb begin
    any_read = |(live & ~is_wr);
    for (int i = 0; i < DEPTH; i++) begin
      el_crit[i] = live[i] && bank_idle[ent_bank[i]] && !is_wr[i] && !crit_done[i];
      el_nc[i]   = live[i] && bank_idle[ent_bank[i]] && !is_wr[i] &&  crit_done[i];
      el_wr[i]   = live[i] && bank_idle[ent_bank[i]] &&  is_wr[i] && !any_read;
    end
    if (|el_crit) begin
      sel_valid = 1'b1; sel_cls = CLS_CRIT;  sel_idx = oldest(el_crit);
    end else if (|el_nc) begin
      sel_valid = 1'b1; sel_cls = CLS_NCRIT; sel_idx = oldest(el_nc);
    end else if (|el_wr) begin
      sel_valid = 1'b1; sel_cls = CLS_WRITE; sel_idx = oldest(el_wr);
    end else begin
      sel_valid = 1'b0; sel_cls = CLS_NONE;  sel_idx = '0;
    end
  end

endmodule

// File: rtl/dram_delay_line.sv
module dram_delay_line #(
  parameter int LEN = 56,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic [LEN-1:0]        v;
  logic [LEN-1:0][W-1:0] d;

  for (genvar s = 0; s < LEN; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) v[0] <= 1'b0;
        else        v[0] <= in_v;
        d[0] <= in_d;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) v[s] <= 1'b0;
        else        v[s] <= v[s-1];
        d[s] <= d[s-1];
      end
    end
  end

  assign out_v = v[LEN-1];
  assign out_d = d[LEN-1];

endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
  import dram_sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NBANKS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 8,
  parameter int T_ADDR = 8,
  parameter int T_RD   = 56,
  parameter int T_WR   = 32,
  parameter int TURN   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic              cmd_crit,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [TAG_W-1:0]  cmd_tag,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              rd_done_valid,
  output logic              rd_done_crit,
  output logic [TAG_W-1:0]  rd_done_tag,
  output logic              wr_start,
  output logic [TAG_W-1:0]  wr_start_tag,
  output logic              fwd_valid,
  output logic [TAG_W-1:0]  fwd_tag,
  output logic [DATA_W-1:0] fwd_data
);
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int BANK_W  = $clog2(NBANKS);
  localparam int GAP_SAT = T_ADDR + TURN;
  localparam int GAP_W   = $clog2(GAP_SAT + 1);

  // Queue view
  logic [CNT_W-1:0]             q_cnt;
  logic [DEPTH-1:0]             q_live, q_wr, q_cd;
  logic [DEPTH-1:0][ADDR_W-1:0] q_addr;
  logic [DEPTH-1:0][TAG_W-1:0]  q_tag;
  logic [DEPTH-1:0][DATA_W-1:0] q_data;
  logic [DEPTH-1:0][BANK_W-1:0] q_bank;
  logic                         lk_hit;
  logic [DATA_W-1:0]            lk_data;

  // Named internal events
  logic      acc_ev, coalesce_ev, push_ev, pop_ev, mark_ev;
  logic      sel_valid, any_read, bus_ok;
  logic [IDX_W-1:0] sel_idx;
  pick_cls_e sel_cls;
  logic [NBANKS-1:0] bank_idle;
  logic [GAP_W-1:0]  gap_cnt;
  logic              last_wr;
  logic [BANK_W-1:0] cmd_bank;

  assign req_ready   = (q_cnt < CNT_W'(DEPTH));
  assign acc_ev      = req_valid && req_ready;
  assign coalesce_ev = acc_ev && !req_write && lk_hit;
  assign push_ev     = acc_ev && !coalesce_ev;

  for (genvar i = 0; i < DEPTH; i++) begin : g_bank_of
    assign q_bank[i] = q_addr[i][BANK_W-1:0];
  end

  dram_req_queue #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push_ev), .push_wr(req_write), .push_addr(req_addr),
    .push_tag(req_tag), .push_data(req_wdata),
    .pop(pop_ev), .pop_idx(sel_idx), .mark(mark_ev), .mark_idx(sel_idx),
    .lk_addr(req_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .cnt(q_cnt), .live(q_live), .q_wr(q_wr), .q_cdone(q_cd),
    .q_addr(q_addr), .q_tag(q_tag), .q_data(q_data)
  );

  dram_issue_pick #(.DEPTH(DEPTH), .NBANKS(NBANKS)) u_pick (
    .live(q_live), .is_wr(q_wr), .crit_done(q_cd), .ent_bank(q_bank),
    .bank_idle(bank_idle), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .sel_cls(sel_cls), .any_read(any_read)
  );

  // Bus pacing: address phase, plus turnaround on a direction change.
  assign cmd_write = (sel_cls == CLS_WRITE);
  assign bus_ok    = (gap_cnt >= GAP_W'(issue_gap(T_ADDR, TURN, cmd_write != last_wr)));
  assign cmd_valid = sel_valid && bus_ok;
  assign cmd_crit  = (sel_cls == CLS_CRIT);
  assign cmd_addr  = q_addr[sel_idx];
  assign cmd_tag   = q_tag[sel_idx];
  assign cmd_wdata = q_data[sel_idx];
  assign cmd_bank  = q_bank[sel_idx];
  assign mark_ev   = cmd_valid && cmd_crit;
  assign pop_ev    = cmd_valid && !cmd_crit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= GAP_W'(GAP_SAT);
      last_wr <= 1'b0;
    end else if (cmd_valid) begin
      gap_cnt <= GAP_W'(1);
      last_wr <= cmd_write;
    end else if (gap_cnt < GAP_W'(GAP_SAT)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  dram_bank_timer #(.NBANKS(NBANKS), .T_RD(T_RD), .T_WR(T_WR)) u_banks (
    .clk(clk), .rst_n(rst_n), .issue(cmd_valid), .issue_bank(cmd_bank),
    .issue_wr(cmd_write), .idle(bank_idle)
  );

  dram_delay_line #(.LEN(T_RD), .W(TAG_W + 1)) u_rd_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_v(cmd_valid && !cmd_write), .in_d({cmd_crit, cmd_tag}),
    .out_v(rd_done_valid), .out_d({rd_done_crit, rd_done_tag})
  );

  dram_delay_line #(.LEN(T_WR), .W(TAG_W)) u_wr_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_v(cmd_valid && cmd_write), .in_d(cmd_tag),
    .out_v(wr_start), .out_d(wr_start_tag)
  );

  // Coalesced read response, one cycle after acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_tag   <= '0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= coalesce_ev;
      if (coalesce_ev) begin
        fwd_tag  <= req_tag;
        fwd_data <= lk_data;
      end
    end
  end

  AST_WR_BEHIND_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |-> !any_read); // R4

  AST_FWD_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (q_cnt <= $past(q_cnt))); // R5

  AST_NO_ISSUE_WHEN_FULL_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !cmd_valid) |=> (q_cnt == $past(q_cnt))); // R9

  if (T_ADDR > 1) begin : g_spacing_chk
    AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R6
    AST_DONE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done_valid |=> !rd_done_valid); // R8
  end

endmodule

// File: tb/dram_req_sched_test.sv
module dram_req_sched_test;
  localparam int DEPTH = 8, NBANKS = 4, ADDR_W = 16, DATA_W = 32, TAG_W = 8;
  localparam int T_ADDR = 8, T_RD = 56, T_WR = 32, TURN = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_ready, req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic cmd_valid, cmd_write, cmd_crit;
  logic [ADDR_W-1:0] cmd_addr;
  logic [TAG_W-1:0]  cmd_tag, rd_done_tag, wr_start_tag, fwd_tag;
  logic [DATA_W-1:0] cmd_wdata, fwd_data;
  logic rd_done_valid, rd_done_crit, wr_start, fwd_valid;

  dram_req_sched #(.DEPTH(DEPTH), .NBANKS(NBANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TAG_W(TAG_W), .T_ADDR(T_ADDR), .T_RD(T_RD), .T_WR(T_WR), .TURN(TURN)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_tag(req_tag), .req_wdata(req_wdata),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_crit(cmd_crit), .cmd_addr(cmd_addr),
    .cmd_tag(cmd_tag), .cmd_wdata(cmd_wdata), .rd_done_valid(rd_done_valid),
    .rd_done_crit(rd_done_crit), .rd_done_tag(rd_done_tag), .wr_start(wr_start),
    .wr_start_tag(wr_start_tag), .fwd_valid(fwd_valid), .fwd_tag(fwd_tag), .fwd_data(fwd_data));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Bench-side rules
  function automatic int min_gap(bit prev_wr, bit now_wr);
    return T_ADDR + ((prev_wr != now_wr) ? TURN : 0);
  endfunction
  function automatic int hold_of(bit was_wr);
    return was_wr ? T_WR : T_RD;
  endfunction

  // Per-tag scoreboard
  bit          t_rd[256], t_acc[256], t_xfwd[256], t_fwd[256];
  logic [ADDR_W-1:0] t_addr[256];
  logic [DATA_W-1:0] t_data[256], t_xdat[256], t_fdat[256];
  int t_ccnt[256], t_ncnt[256], t_wcnt[256], t_ct[256], t_nt[256], t_wt[256];
  int t_dc[256], t_dn[256], t_ws[256];
  int sq[$];               // shadow queue of tags, oldest first
  int pend_rd = 0, outst = 0;
  int last_t = -1000; bit last_w = 0;
  int bank_t[NBANKS]; bit bank_w[NBANKS]; bit bank_u[NBANKS];
  int log_tag[$], log_t[$], log_k[$];   // k: 0 crit, 1 ncrit, 2 write
  bit m_hit; logic [DATA_W-1:0] m_hd; int tg, b;

  initial for (int i = 0; i < NBANKS; i++) bank_u[i] = 0;

  task automatic sq_remove(int tag);
    for (int k = 0; k < sq.size(); k++)
      if (sq[k] == tag) begin sq.delete(k); break; end
  endtask

  always @(negedge clk) if (rst_n) begin
    // coalescing expectation uses queue contents before this cycle's command
    m_hit = 0; m_hd = '0;
    if (req_valid && req_ready && !req_write)
      foreach (sq[k]) if (!t_rd[sq[k]] && t_addr[sq[k]] == req_addr) begin
        m_hit = 1; m_hd = t_data[sq[k]];
      end
    if (cmd_valid) begin
      tg = int'(cmd_tag); b = int'(cmd_addr[1:0]);
      check(cyc - last_t >= min_gap(last_w, cmd_write), "R6", "cmd gap", cyc - last_t,
            min_gap(last_w, cmd_write));
      if (bank_u[b])
        check(cyc - bank_t[b] >= hold_of(bank_w[b]), "R7", "bank hold", cyc - bank_t[b],
              hold_of(bank_w[b]));
      check(cmd_addr == t_addr[tg], "R2", "cmd addr", cmd_addr, t_addr[tg]);
      if (cmd_write) begin
        check(pend_rd == 0, "R4", "write passed read", pend_rd, 0);
        check(cmd_wdata == t_data[tg], "R2", "write data", cmd_wdata, t_data[tg]);
        t_wcnt[tg]++; t_wt[tg] = cyc; sq_remove(tg); log_k.push_back(2);
      end else if (cmd_crit) begin
        check(t_ccnt[tg] == 0, "R2", "crit count", t_ccnt[tg], 0);
        t_ccnt[tg]++; t_ct[tg] = cyc; log_k.push_back(0);
      end else begin
        check(t_ccnt[tg] == 1, "R2", "ncrit before crit", t_ccnt[tg], 1);
        t_ncnt[tg]++; t_nt[tg] = cyc; sq_remove(tg); pend_rd--; log_k.push_back(1);
      end
      log_tag.push_back(tg); log_t.push_back(cyc);
      last_t = cyc; last_w = cmd_write;
      bank_t[b] = cyc; bank_w[b] = cmd_write; bank_u[b] = 1;
    end
    if (rd_done_valid) begin
      tg = int'(rd_done_tag);
      if (rd_done_crit) begin
        check(cyc - t_ct[tg] == T_RD, "R8", "crit done delay", cyc - t_ct[tg], T_RD);
        t_dc[tg]++;
      end else begin
        check(cyc - t_nt[tg] == T_RD, "R8", "ncrit done delay", cyc - t_nt[tg], T_RD);
        t_dn[tg]++; outst--;
      end
    end
    if (wr_start) begin
      tg = int'(wr_start_tag);
      check(cyc - t_wt[tg] == T_WR, "R8", "write start delay", cyc - t_wt[tg], T_WR);
      t_ws[tg]++; outst--;
    end
    if (fwd_valid) begin
      tg = int'(fwd_tag);
      check(t_xfwd[tg], "R5", "unexpected forward", tg, 0);
      t_fwd[tg] = 1; t_fdat[tg] = fwd_data; outst--;
    end
    if (req_valid && req_ready) begin
      tg = int'(req_tag);
      t_acc[tg] = 1; t_rd[tg] = !req_write; t_addr[tg] = req_addr; t_data[tg] = req_wdata;
      t_xfwd[tg] = m_hit; t_xdat[tg] = m_hd; outst++;
      if (!m_hit) begin
        sq.push_back(tg);
        if (!req_write) pend_rd++;
      end
    end
  end

  task automatic send(bit wr, logic [ADDR_W-1:0] a, logic [TAG_W-1:0] tag, logic [DATA_W-1:0] d);
    bit ok;
    req_valid = 1; req_write = wr; req_addr = a; req_tag = tag; req_wdata = d;
    forever begin
      ok = req_ready;
      @(posedge clk); #1;
      if (ok) break;
    end
    req_valid = 0;
  endtask

  task automatic drain();
    while (outst != 0 || sq.size() != 0) begin @(posedge clk); #1; end
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic clear_log();
    log_tag.delete(); log_t.delete(); log_k.delete();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000 - 50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int exp_t[7], exp_g[7], exp_k[7];
    for (int i = 0; i < 256; i++) begin
      t_rd[i] = 0; t_acc[i] = 0; t_xfwd[i] = 0; t_fwd[i] = 0;
      t_ccnt[i] = 0; t_ncnt[i] = 0; t_wcnt[i] = 0; t_dc[i] = 0; t_dn[i] = 0; t_ws[i] = 0;
      t_ct[i] = 0; t_nt[i] = 0; t_wt[i] = 0; t_addr[i] = '0; t_data[i] = '0;
    end
    void'($urandom(32'd2468));
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1, "R1", "ready", req_ready, 1);
    check(!cmd_valid && !rd_done_valid && !wr_start && !fwd_valid, "R1", "outputs idle",
          {cmd_valid, rd_done_valid, wr_start, fwd_valid}, 0);
    @(posedge clk); #1;

    // R3/R4/R6/R7: fixed contention pattern with exact command cycles
    clear_log();
    send(0, 16'h0010, 8'd1, '0);
    send(1, 16'h0021, 8'd2, 32'h1111_2222);
    send(0, 16'h0032, 8'd3, '0);
    send(0, 16'h0043, 8'd4, '0);
    drain();
    exp_t = '{1, 3, 4, 1, 3, 4, 2};
    exp_k = '{0, 0, 0, 1, 1, 1, 2};
    exp_g = '{0, 8, 16, 56, 64, 72, 81};
    check(log_tag.size() == 7, "R3", "command count", log_tag.size(), 7);
    if (log_tag.size() == 7)
      for (int i = 0; i < 7; i++) begin
        check(log_tag[i] == exp_t[i] && log_k[i] == exp_k[i], "R3", "issue order",
              {log_tag[i], log_k[i]}, {exp_t[i], exp_k[i]});
        check(log_t[i] - log_t[0] == exp_g[i], (i == 6) ? "R6" : "R7", "issue cycle",
              log_t[i] - log_t[0], exp_g[i]);
      end

    // R5: two writes to one line held behind a read, then a read of that line
    send(0, 16'h0200, 8'd10, '0);
    send(1, 16'h0105, 8'd11, 32'hA5A5_0001);
    send(1, 16'h0105, 8'd12, 32'h5A5A_0002);
    send(0, 16'h0105, 8'd13, '0);
    drain();
    check(t_fwd[13], "R5", "forward seen", t_fwd[13], 1);
    check(t_fdat[13] == 32'h5A5A_0002, "R5", "youngest data", t_fdat[13], 32'h5A5A_0002);
    check(t_ccnt[13] == 0 && t_ncnt[13] == 0, "R5", "no bus command", t_ccnt[13] + t_ncnt[13], 0);

    // R9 and R3 oldest-first: fill queue with reads to bank 0
    clear_log();
    for (int i = 0; i < DEPTH; i++) send(0, 16'h0300 + 16'(i * 4), 8'(20 + i), '0);
    req_valid = 1; req_write = 0; req_addr = 16'h0304; req_tag = 8'd28;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(req_ready == 0, "R9", "ready while full", req_ready, 0);
      @(posedge clk); #1;
    end
    req_valid = 0;
    drain();
    check(!t_acc[28] && t_ccnt[28] == 0 && t_dc[28] == 0, "R9", "held request ignored",
          t_acc[28] + t_ccnt[28] + t_dc[28], 0);
    check(log_tag.size() == 2 * DEPTH, "R3", "full-queue commands", log_tag.size(), 2 * DEPTH);
    if (log_tag.size() == 2 * DEPTH)
      for (int i = 0; i < 2 * DEPTH; i++)
        check(log_tag[i] == 20 + (i % DEPTH) && log_k[i] == (i / DEPTH), "R3", "oldest first",
              log_tag[i], 20 + (i % DEPTH));

    // Random traffic over a small pool of lines
    for (int k = 0; k < 150; k++) begin
      int gap;
      bit wr;
      wr = ($urandom_range(0, 99) < 35);
      send(wr, 16'($urandom_range(0, 11)), 8'(40 + k), $urandom());
      gap = $urandom_range(0, 3);
      repeat (gap) @(posedge clk);
      #1;
    end
    drain();
    for (int k = 40; k < 190; k++) begin
      if (!t_rd[k])
        check(t_wcnt[k] == 1 && t_ws[k] == 1, "R8", "write issued once", t_ws[k], 1);
      else if (t_xfwd[k])
        check(t_fwd[k] && t_fdat[k] == t_xdat[k] && t_ccnt[k] == 0, "R5", "random forward",
              t_fdat[k], t_xdat[k]);
      else
        check(t_ccnt[k] == 1 && t_ncnt[k] == 1 && t_dc[k] == 1 && t_dn[k] == 1, "R2",
              "read split", {t_ccnt[k], t_ncnt[k]}, {32'd1, 32'd1});
    end
    summary();
  end

endmodule